// File: doc/BRIEF.md
# Contact-Qualified One-Shot Pulse Generator

This block watches a single-bit contact input. The input is high while a pair of test probes touches a passive load. The input first goes through a synchronizer. The block then waits until the contact has been steady for a programmable number of clock cycles. At that point it fires one pulse of programmable length. For the whole of that pulse, three outputs go high together: an enable for the positive-side probe switch, an enable for the negative-side probe switch, and an indicator.

A pulse that has started always runs to its end, even if the probes lift off partway through. After the pulse the block stays quiet. It re-arms only once the contact has been released and that release has itself passed the same qualification time. A contact that is held, or one that bounces on release, therefore yields exactly one pulse. Short touches and bounces while the contact is being qualified produce nothing.

Top module: `contact_pulser`

## Requirements
- R1: A pulse starts only after debounce_cycles+1 consecutive synchronized high samples of the contact. A contact that is shorter, counted in synchronized samples, produces no pulse.
- R2: Each contact produces exactly one pulse. Re-arming requires debounce_cycles+1 consecutive synchronized low samples after the pulse ends. A high sample during that window restarts the release count. After a pulse falls, the outputs stay low for at least one cycle.
- R3: A pulse lasts max(pulse_cycles,1) clock cycles. The value of pulse_cycles is captured in the cycle the pulse starts, so later changes do not affect a pulse in progress.
- R4: Once started, a pulse runs its full length even if the contact goes low during it.
- R5: pos_en, neg_en and indicator are high in exactly the same cycles, and only while a pulse is active.
- R6: contact_in passes through a two-flop synchronizer before it is qualified. With debounce_cycles=0, a contact first driven high before clock edge k makes the outputs go high after edge k+2.
- R7: With debounce_cycles=0, the first synchronized high sample starts the pulse, and a single synchronized low sample after the pulse re-arms the block.
- R8: A low synchronized sample while the contact is being qualified discards the count already accumulated. The next contact must again supply debounce_cycles+1 consecutive high samples.
- R9: While rst_n is low (asynchronous, active low), all outputs are low and the block is armed and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| contact_in | input | 1 | Probe-contact sense, high while a load is present |
| debounce_cycles | input | CNT_W | Qualification time for both contact and release |
| pulse_cycles | input | CNT_W | Pulse length in cycles (0 is treated as 1) |
| pos_en | output | 1 | Positive-side probe switch enable |
| neg_en | output | 1 | Negative-side probe switch enable |
| indicator | output | 1 | Pulse-issued indicator |

## Verification
Two of the block's functions can fall in the same cycle. The first pair is the end of a pulse and the loss of contact. The bench drops the contact while the pulse is still running and checks that the pulse keeps going to its programmed length. The second pair is the first cycle of the release window and a contact bounce. The bench raises the contact again for a few cycles just after the pulse ends, then checks that no second pulse appears and that re-arming waits for a fresh run of low samples. A behavioural model tracks the synchronizer delay and the high and low run lengths, and its expected output is compared with the three outputs on every clock.

// File: rtl/contact_pulser_pkg.sv
package contact_pulser_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_FIRE    = 2'd2,
        ST_RELEASE = 2'd3
    } pulser_state_e;

endpackage

// File: rtl/contact_sync.sv
module contact_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pulse_sequencer.sv
module pulse_sequencer
    import contact_pulser_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             contact_s,
    input  logic [CNT_W-1:0] debounce_cycles,
    input  logic [CNT_W-1:0] pulse_cycles,
    output logic             pulse_on
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        pulser_state_e    st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [CNT_W-1:0] len_eff;

    assign len_eff = (pulse_cycles == '0) ? ONE : pulse_cycles;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_ARMED: begin
                seq_d.cnt = '0;
                if (contact_s) begin
                    seq_d.cnt = ONE;
                    if (debounce_cycles == '0) begin
                        seq_d.st  = ST_FIRE;
                        seq_d.len = len_eff;
                    end else begin
                        seq_d.st = ST_QUALIFY;
                    end
                end
            end
            ST_QUALIFY: begin
                if (!contact_s) begin
                    seq_d.st  = ST_ARMED;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt >= debounce_cycles) begin
                    seq_d.st  = ST_FIRE;
                    seq_d.cnt = ONE;
                    seq_d.len = len_eff;
                end else begin
                    seq_d.cnt = seq_q.cnt + ONE;
                end
            end
            ST_FIRE: begin
                if (seq_q.cnt >= seq_q.len) begin
                    seq_d.st  = ST_RELEASE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + ONE;
                end
            end
            ST_RELEASE: begin
                if (contact_s) begin
                    seq_d.cnt = '0;
                end else if (seq_q.cnt >= debounce_cycles) begin
                    seq_d.st  = ST_ARMED;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + ONE;
                end
            end
            default: seq_d = '{st: ST_ARMED, cnt: '0, len: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_ARMED, cnt: '0, len: '0};
        else        seq_q <= seq_d;
    end

    assign pulse_on = (seq_q.st == ST_FIRE);
endmodule

// File: rtl/contact_pulser.sv
module contact_pulser #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             contact_in,
    input  logic [CNT_W-1:0] debounce_cycles,
    input  logic [CNT_W-1:0] pulse_cycles,
    output logic             pos_en,
    output logic             neg_en,
    output logic             indicator
);
    logic contact_s;
    logic pulse_on;

    contact_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (contact_in),
        .sync_out (contact_s)
    );

    pulse_sequencer #(.CNT_W(CNT_W)) seq_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .contact_s       (contact_s),
        .debounce_cycles (debounce_cycles),
        .pulse_cycles    (pulse_cycles),
        .pulse_on        (pulse_on)
    );

    assign pos_en    = pulse_on;
    assign neg_en    = pulse_on;
    assign indicator = pulse_on;
endmodule

// File: rtl/contact_pulser_chk.sv
module contact_pulser_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             contact_in,
    input logic             contact_s,
    input logic [CNT_W-1:0] pulse_cycles,
    input logic             pos_en
);
    logic [1:0]       age_q;
    logic             pe_prev_q;
    logic [CNT_W-1:0] pc_prev_q;
    logic [CNT_W-1:0] run_len_q;
    logic [CNT_W-1:0] exp_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q     <= '0;
            pe_prev_q <= 1'b0;
            pc_prev_q <= '0;
            run_len_q <= '0;
            exp_len_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            pe_prev_q <= pos_en;
            pc_prev_q <= pulse_cycles;
            if (pos_en) run_len_q <= pe_prev_q ? run_len_q + CNT_W'(1) : CNT_W'(1);
            if (pos_en && !pe_prev_q)
                exp_len_q <= (pc_prev_q == '0) ? CNT_W'(1) : pc_prev_q;
        end
    end

    // R1: a pulse only begins on a cycle whose synchronized contact was high
    assert_start_after_contact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_en) |-> $past(contact_s));

    // R2: at least one quiet cycle between pulses
    assert_gap_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pos_en) |=> !pos_en);

    // R3: measured pulse length equals captured length
    assert_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_prev_q && !pos_en) |-> (run_len_q == exp_len_q));

    // R6: synchronized contact trails the input by two edges
    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (contact_s == $past(contact_in, 2)));
endmodule

bind contact_pulser contact_pulser_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .contact_in   (contact_in),
    .contact_s    (contact_s),
    .pulse_cycles (pulse_cycles),
    .pos_en       (pos_en)
);

// File: tb/contact_pulser_tb_top.sv
`timescale 1ns/1ps
module contact_pulser_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             contact_in = 1'b0;
    logic [CNT_W-1:0] debounce_cycles = '0;
    logic [CNT_W-1:0] pulse_cycles = '0;
    logic             pos_en, neg_en, indicator;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    contact_pulser #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .contact_in(contact_in),
        .debounce_cycles(debounce_cycles), .pulse_cycles(pulse_cycles),
        .pos_en(pos_en), .neg_en(neg_en), .indicator(indicator)
    );

    // behavioural reference: delay line, run counters, remaining pulse time
    int  p1 = 0, p2 = 0;
    int  mode = 0;          // 0 armed, 1 firing, 2 awaiting release
    int  hi_run = 0, lo_run = 0, left = 0;
    bit  model_on = 0;

    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            p1 = 0; p2 = 0; mode = 0; hi_run = 0; lo_run = 0; left = 0; model_on = 0;
        end else begin
            s  = p2;
            p2 = p1;
            p1 = contact_in;
            case (mode)
                0: begin
                    if (s != 0) begin
                        hi_run++;
                        if (hi_run >= int'(debounce_cycles) + 1) begin
                            mode = 1; hi_run = 0;
                            left = (pulse_cycles == 0) ? 1 : int'(pulse_cycles);
                        end
                    end else hi_run = 0;
                end
                1: begin
                    left--;
                    if (left == 0) begin mode = 2; lo_run = 0; end
                end
                default: begin
                    if (s != 0) lo_run = 0;
                    else begin
                        lo_run++;
                        if (lo_run >= int'(debounce_cycles) + 1) begin mode = 0; hi_run = 0; end
                    end
                end
            endcase
            model_on = (mode == 1);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // pulse statistics and per-cycle comparison, away from the rising edge
    int  pulses = 0;
    int  cur_len = 0, last_len = 0;
    bit  prev_pe = 0;

    always @(negedge clk) begin
        if (!finished) begin
            check({cur_req, " R5 outputs vs model"}, {pos_en, neg_en, indicator},
                  model_on ? 3'b111 : 3'b000);
            if (pos_en && !prev_pe) begin pulses++; cur_len = 0; end
            if (pos_en) cur_len++;
            if (!pos_en && prev_pe) last_len = cur_len;
            prev_pe = pos_en;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic touch(input int hi, input int lo);
        contact_in = 1'b1; cyc(hi);
        contact_in = 1'b0; cyc(lo);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        // R9: reset state
        check("R9 outputs in reset", {pos_en, neg_en, indicator}, 0);
        rst_n = 1'b1; cyc(2);
        check("R9 idle after reset", pos_en, 0);

        // R1: short touch rejected (needs 5 samples, supply 4)
        cur_req = "R1"; debounce_cycles = 4; pulse_cycles = 3; pulses = 0;
        touch(4, 20);
        check("R1 short touch no pulse", pulses, 0);

        // R1/R2: held contact gives one pulse only
        cur_req = "R2"; pulse_cycles = 5; pulses = 0;
        touch(60, 20);
        check("R2 one pulse per held contact", pulses, 1);
        check("R3 pulse length 5", last_len, 5);
        pulses = 0; touch(30, 20);
        check("R2 retouch after release fires again", pulses, 1);

        // R4: contact lost during pulse
        cur_req = "R4"; debounce_cycles = 3; pulse_cycles = 10; pulses = 0;
        touch(7, 30);
        check("R4 pulse count", pulses, 1);
        check("R4 full length despite drop", last_len, 10);

        // R3: zero length treated as one
        cur_req = "R3"; pulse_cycles = 0; pulses = 0;
        touch(10, 20);
        check("R3 zero length gives one cycle", last_len, 1);

        // R3: length captured at start
        pulse_cycles = 6; pulses = 0;
        contact_in = 1'b1; cyc(8);
        pulse_cycles = 2; cyc(20);
        contact_in = 1'b0; cyc(20);
        check("R3 captured length 6", last_len, 6);
        pulse_cycles = 4;

        // R6/R7: zero debounce, single-cycle touch, exact latency
        cur_req = "R7"; debounce_cycles = 0; pulses = 0;
        contact_in = 1'b1; cyc(1);
        contact_in = 1'b0;
        check("R6 not yet high after 1 edge", pos_en, 0);
        cyc(1);
        check("R6 not yet high after 2 edges", pos_en, 0);
        cyc(1);
        check("R6 high after third edge", pos_en, 1);
        cyc(15);
        check("R7 one-sample touch fires", pulses, 1);
        pulses = 0; touch(1, 15);
        check("R7 single low sample re-arms", pulses, 1);

        // R8: bounce during qualification restarts the count
        cur_req = "R8"; debounce_cycles = 5; pulses = 0;
        touch(5, 1); touch(5, 1); touch(4, 20);
        check("R8 bounced qualification no pulse", pulses, 0);
        touch(6, 30);
        check("R8 clean contact after bounce fires", pulses, 1);

        // R2: bounce during release window
        cur_req = "R2"; debounce_cycles = 4; pulse_cycles = 2; pulses = 0;
        contact_in = 1'b1; cyc(15);
        contact_in = 1'b0; cyc(2);
        contact_in = 1'b1; cyc(3);
        contact_in = 1'b0; cyc(3);
        contact_in = 1'b1; cyc(20);
        contact_in = 1'b0; cyc(20);
        check("R2 release bounce no extra pulse", pulses, 1);
        pulses = 0; touch(12, 20);
        check("R2 re-armed after clean release", pulses, 1);

        finish_run();
    end
endmodule